// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address (a segment number and an offset within that segment) into a flat physical address. Each request also carries the kind of access wanted: read, write or execute. Two configuration registers set where the segment table sits in memory and how many segments it holds. Only a privileged writer can change them.

A request whose segment number is in range causes a fetch of that segment's descriptor from memory. The fetch reads two 32-bit words over a request/acknowledge port. The descriptor gives:

- the segment's starting physical address,
- its length in bytes,
- a presence flag,
- three permission flags.

The block checks the descriptor against the request and answers with either a translated address or a fault code that says which check failed first.

One request is handled at a time. The block signals when it can take the next one, and every accepted request produces exactly one single-cycle response.

Top module: `seg_xlate`

## Requirements
- R1: After reset the block is ready (`req_ready`=1), issues no memory read and gives no response, and both configuration registers hold 0, so every request gets a length fault.
- R2: A configuration write takes effect only when `cfg_priv`=1 in the same cycle as `cfg_we`. `cfg_sel`=0 writes the table base address and `cfg_sel`=1 writes the table segment count from `cfg_wdata[16:0]`. An unprivileged write leaves both registers unchanged.
- R3: A segment number not below the segment count is answered with fault code 0 in the cycle after acceptance, and no memory read is issued for it.
- R4: For an in-range segment, the descriptor is read as two words. The first is at table base + 8 × segment number and the second is at that address + 4. Each address stays stable while `mem_req` waits for `mem_ack`.
- R5: Descriptor layout: word 0 is the 32-bit segment base. Word 1 holds the limit in bits 15:0, the present flag in bit 16, and the read, write and execute permissions in bits 17, 18 and 19. A clear present flag gives fault code 1.
- R6: An offset greater than or equal to the limit gives fault code 2. A limit of 0 therefore rejects every offset, and an offset of limit − 1 is accepted.
- R7: Access code 0 (read) needs bit 17, code 1 (write) needs bit 18 and code 2 (execute) needs bit 19. Code 3 is never allowed. A missing permission gives fault code 3.
- R8: The checks apply in the order length, present, limit, permission, and only the first failing one is reported.
- R9: On success `rsp_ok`=1 and `rsp_paddr` is segment base + offset, modulo 2^32. On any fault `rsp_ok`=0 and `rsp_paddr`=0.
- R10: While a descriptor fetch is outstanding `req_ready` is 0. Each accepted request yields exactly one `rsp_valid` pulse, and responses come in acceptance order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Writer is privileged |
| cfg_sel | input | 1 | 0: table base, 1: segment count |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | 16 | Segment number |
| req_off | input | 16 | Offset within segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_fault | output | 2 | Fault code 0 length, 1 absent, 2 limit, 3 permission |
| rsp_paddr | output | 32 | Physical address, 0 on fault |

## Verification
The assertions assume the memory side follows the port contract:

- `mem_ack` is raised only while `mem_req` is high.
- `mem_ack` lasts one cycle per word.
- The configuration registers are not rewritten while a descriptor fetch is in flight, so a fetch always sees one table base.

The bench's memory model answers on the falling edge and drops its acknowledge after a single cycle. Configuration writes are issued only after the scoreboard queue has drained, and requests are presented only while `req_ready` is high.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int ADDR_W = 32;
  localparam int LIM_W  = 16;
  localparam int ATTR_W = LIM_W + 4;

  localparam int BIT_PRESENT = LIM_W;
  localparam int BIT_RD      = LIM_W + 1;
  localparam int BIT_WR      = LIM_W + 2;
  localparam int BIT_EX      = LIM_W + 3;

  typedef enum logic [1:0] {
    FLT_LEN     = 2'd0,
    FLT_ABSENT  = 2'd1,
    FLT_LIMIT   = 2'd2,
    FLT_PERM    = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              present;
    logic              may_rd;
    logic              may_wr;
    logic              may_ex;
  } seg_desc_t;

  function automatic seg_desc_t unpack_desc(input logic [ADDR_W-1:0] w0,
                                            input logic [ATTR_W-1:0] w1);
    seg_desc_t d;
    d.base    = w0;
    d.limit   = w1[LIM_W-1:0];
    d.present = w1[BIT_PRESENT];
    d.may_rd  = w1[BIT_RD];
    d.may_wr  = w1[BIT_WR];
    d.may_ex  = w1[BIT_EX];
    return d;
  endfunction

  function automatic logic access_allowed(input access_e acc, input seg_desc_t d);
    case (acc)
      ACC_READ:  return d.may_rd;
      ACC_WRITE: return d.may_wr;
      ACC_EXEC:  return d.may_ex;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] desc_addr(input logic [ADDR_W-1:0] tbl,
                                                  input logic [SEG_W-1:0] seg);
    return tbl + (ADDR_W'(seg) << 3);
  endfunction

  function automatic logic [ADDR_W-1:0] phys_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [OFF_W-1:0] off);
    return base + ADDR_W'(off);
  endfunction
endpackage

// File: rtl/segx_cfg_regs.sv
module segx_cfg_regs
  import segx_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEG_W,
  localparam int LW = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_priv,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] tbl_base,
  output logic [LW-1:0] tbl_len
);
  logic commit;
  assign commit = cfg_we && cfg_priv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base <= '0;
      tbl_len  <= '0;
    end else if (commit) begin
      if (cfg_sel) tbl_len  <= cfg_wdata[LW-1:0];
      else         tbl_base <= cfg_wdata;
    end
  end
endmodule

// File: rtl/segx_judge.sv
module segx_judge
  import segx_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W
) (
  input  logic [AW-1:0]     word0,
  input  logic [ATTR_W-1:0] word1,
  input  logic [OW-1:0]     off,
  input  access_e           acc,
  output logic              ok,
  output fault_e            fault,
  output logic [AW-1:0]     paddr
);
  seg_desc_t d;
  assign d = unpack_desc(word0, word1);

  always_comb begin
    ok    = 1'b0;
    fault = FLT_ABSENT;
    if (!d.present)                    fault = FLT_ABSENT;
    else if (off >= d.limit)           fault = FLT_LIMIT;
    else if (!access_allowed(acc, d))  fault = FLT_PERM;
    else begin
      ok    = 1'b1;
      fault = FLT_LEN;
    end
  end

  assign paddr = ok ? phys_addr(d.base, off) : '0;
endmodule

// File: rtl/segx_walker.sv
module segx_walker
  import segx_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEG_W,
  parameter int OW = OFF_W,
  localparam int LW = SW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SW-1:0]     req_seg,
  input  logic [OW-1:0]     req_off,
  input  access_e           req_acc,
  input  logic [AW-1:0]     tbl_base,
  input  logic [LW-1:0]     tbl_len,
  output logic              req_ready,
  output logic              len_fault,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_ack,
  input  logic [AW-1:0]     mem_rdata,
  output logic [AW-1:0]     word0,
  output logic [ATTR_W-1:0] word1,
  output logic [OW-1:0]     off_q,
  output access_e           acc_q,
  input  logic              judge_ok,
  input  fault_e            judge_fault,
  input  logic [AW-1:0]     judge_paddr,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output fault_e            rsp_fault,
  output logic [AW-1:0]     rsp_paddr
);
  typedef enum logic [1:0] {W_IDLE, W_RD0, W_RD1, W_JUDGE} wstate_e;
  wstate_e       state;
  logic [AW-1:0] ent_addr;
  logic          accept;

  assign req_ready = (state == W_IDLE);
  assign accept    = req_valid && req_ready;
  assign len_fault = accept && ({1'b0, req_seg} >= tbl_len);
  assign mem_req   = (state == W_RD0) || (state == W_RD1);
  assign mem_addr  = (state == W_RD1) ? ent_addr + AW'(4) : ent_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= W_IDLE;
      ent_addr  <= '0;
      word0     <= '0;
      word1     <= '0;
      off_q     <= '0;
      acc_q     <= ACC_READ;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_fault <= FLT_LEN;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        W_IDLE: if (accept) begin
          if (len_fault) begin
            rsp_valid <= 1'b1;
            rsp_ok    <= 1'b0;
            rsp_fault <= FLT_LEN;
            rsp_paddr <= '0;
          end else begin
            ent_addr <= desc_addr(tbl_base, req_seg);
            off_q    <= req_off;
            acc_q    <= req_acc;
            state    <= W_RD0;
          end
        end
        W_RD0: if (mem_ack) begin
          word0 <= mem_rdata;
          state <= W_RD1;
        end
        W_RD1: if (mem_ack) begin
          word1 <= mem_rdata[ATTR_W-1:0];
          state <= W_JUDGE;
        end
        default: begin
          rsp_valid <= 1'b1;
          rsp_ok    <= judge_ok;
          rsp_fault <= judge_fault;
          rsp_paddr <= judge_paddr;
          state     <= W_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import segx_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEG_W,
  parameter int OW = OFF_W,
  localparam int LW = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_priv,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_seg,
  input  logic [OW-1:0] req_off,
  input  logic [1:0]    req_acc,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic [1:0]    rsp_fault,
  output logic [AW-1:0] rsp_paddr
);
  logic [AW-1:0]     tbl_base;
  logic [LW-1:0]     tbl_len;
  logic              len_fault;
  logic [AW-1:0]     word0;
  logic [ATTR_W-1:0] word1;
  logic [OW-1:0]     off_q;
  access_e           acc_q;
  logic              judge_ok;
  fault_e            judge_fault;
  logic [AW-1:0]     judge_paddr;
  fault_e            rsp_fault_e;

  segx_cfg_regs #(.AW(AW), .SW(SW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tbl_base(tbl_base), .tbl_len(tbl_len)
  );

  segx_walker #(.AW(AW), .SW(SW), .OW(OW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
    .req_acc(access_e'(req_acc)),
    .tbl_base(tbl_base), .tbl_len(tbl_len),
    .req_ready(req_ready), .len_fault(len_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .word0(word0), .word1(word1), .off_q(off_q), .acc_q(acc_q),
    .judge_ok(judge_ok), .judge_fault(judge_fault), .judge_paddr(judge_paddr),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault_e), .rsp_paddr(rsp_paddr)
  );

  segx_judge #(.AW(AW), .OW(OW)) u_judge (
    .word0(word0), .word1(word1), .off(off_q), .acc(acc_q),
    .ok(judge_ok), .fault(judge_fault), .paddr(judge_paddr)
  );

  assign rsp_fault = rsp_fault_e;
endmodule

// File: rtl/segx_sva.sv
module segx_sva #(
  parameter int AW = 32,
  parameter int SW = 16,
  localparam int LW = SW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          cfg_priv,
  input logic [AW-1:0] tbl_base,
  input logic [LW-1:0] tbl_len,
  input logic          req_valid,
  input logic          req_ready,
  input logic [SW-1:0] req_seg,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          rsp_valid,
  input logic          rsp_ok,
  input logic [1:0]    rsp_fault,
  input logic [AW-1:0] rsp_paddr
);
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_priv |=> $stable(tbl_base) && $stable(tbl_len)); // R2

  AST_LEN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ({1'b0, req_seg} >= tbl_len)
      |=> rsp_valid && !rsp_ok && rsp_fault == 2'd0 && !mem_req); // R3

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R4

  AST_OK_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ok |-> $past(mem_ack, 2)); // R4

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ok |-> rsp_paddr == '0); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R10
endmodule

bind seg_xlate segx_sva #(.AW(AW), .SW(SW)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
  .tbl_base(tbl_base), .tbl_len(tbl_len),
  .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_seg = '0, req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_ok;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  seg_xlate dut (.*);

  typedef struct {
    int          seg;
    logic        ok;
    logic [1:0]  fault;
    logic [31:0] paddr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // bench-side model of the table
  logic [31:0] m_tbl;
  int          m_len;
  logic [31:0] ent_base [8];
  logic [31:0] ent_attr [8];
  int          cur_seg;
  int          rd_phase;
  int          reads;

  task automatic note(input bit good, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory model: one-cycle acknowledge, checks the address it is given
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      logic [31:0] exp_a;
      exp_a = m_tbl + 32'(cur_seg) * 8 + 32'(rd_phase) * 4;
      note(mem_addr == exp_a, "R4", "read address", 64'(mem_addr), 64'(exp_a));
      if (rd_phase == 0) mem_rdata <= ent_base[cur_seg % 8];
      else               mem_rdata <= ent_attr[cur_seg % 8];
      rd_phase = 1 - rd_phase;
      reads++;
      mem_ack <= 1'b1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) note(1'b0, "R10", "unexpected response", 64'(rsp_fault), 64'hx);
      else begin
        exp_t e;
        bit   good;
        e = sb.pop_front();
        good = (rsp_ok === e.ok) && (rsp_fault === e.fault) && (rsp_paddr === e.paddr);
        note(good, e.tag, $sformatf("seg %0d ok/fault/paddr", e.seg),
             {rsp_ok, rsp_fault, 29'd0, rsp_paddr}, {e.ok, e.fault, 29'd0, e.paddr});
      end
    end
  end

  function automatic exp_t predict(input int seg, input int off, input int acc, input string tag);
    exp_t  e;
    logic [31:0] a;
    bit    perm;
    e.seg = seg; e.tag = tag; e.ok = 1'b0; e.paddr = '0;
    if (seg >= m_len) begin e.fault = 2'd0; return e; end
    a = ent_attr[seg];
    if (a[16] == 1'b0)          e.fault = 2'd1;
    else if (off >= int'(a[15:0])) e.fault = 2'd2;
    else begin
      perm = (acc == 0) ? a[17] : (acc == 1) ? a[18] : (acc == 2) ? a[19] : 1'b0;
      if (!perm) e.fault = 2'd3;
      else begin
        e.ok = 1'b1; e.fault = 2'd0;
        e.paddr = ent_base[seg] + 32'(off);
      end
    end
    return e;
  endfunction

  task automatic send(input int seg, input int off, input int acc, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_seg = seg; rd_phase = 0;
    sb.push_back(predict(seg, off, acc, tag));
    req_valid = 1'b1; req_seg = 16'(seg); req_off = 16'(off); req_acc = 2'(acc);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input bit priv, input bit sel, input logic [31:0] d);
    drain();
    cfg_priv = priv; cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
    if (priv) begin if (sel) m_len = int'(d[16:0]); else m_tbl = d; end
  endtask

  function automatic logic [31:0] attr(input int lim, input bit p, input bit r, input bit w, input bit x);
    return {12'd0, x, w, r, p, 16'(lim)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    m_tbl = '0; m_len = 0; cur_seg = 0; rd_phase = 0; reads = 0;
    ent_base[0] = 32'h8000_0000; ent_attr[0] = attr(16'h100, 1, 1, 1, 1);
    ent_base[1] = 32'h1111_0000; ent_attr[1] = attr(0, 0, 1, 1, 1);
    ent_base[2] = 32'h0002_0000; ent_attr[2] = attr(16'h40, 1, 1, 0, 0);
    ent_base[3] = 32'h0003_0000; ent_attr[3] = attr(0, 1, 0, 0, 0);
    ent_base[4] = 32'hFFFF_FFF0; ent_attr[4] = attr(16'hFFFF, 1, 1, 1, 0);
    ent_base[5] = 32'h0005_0000; ent_attr[5] = attr(16'h10, 1, 0, 0, 1);
    ent_base[6] = 32'h0006_0000; ent_attr[6] = attr(16'h10, 1, 1, 1, 1);
    ent_base[7] = 32'h0007_0000; ent_attr[7] = attr(16'h10, 1, 1, 1, 1);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    note(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
    note(mem_req == 1'b0 && rsp_valid == 1'b0, "R1", "idle outputs after reset",
         64'({mem_req, rsp_valid}), 64'd0);
    send(0, 0, 0, "R1");   // count is 0 -> length fault
    drain();

    // R2: unprivileged writes are dropped
    cfg_write(1'b0, 1'b1, 32'd8);
    send(0, 4, 0, "R2");
    cfg_write(1'b1, 1'b0, 32'h0000_1000);
    cfg_write(1'b1, 1'b1, 32'd6);
    cfg_write(1'b0, 1'b0, 32'h0000_5000);
    send(0, 16, 0, "R2");  // base must still be 0x1000 (R4 address check)
    drain();

    // R4: exactly two reads for a fetch
    r0 = reads;
    send(0, 8, 1, "R4");
    drain();
    note(reads - r0 == 2, "R4", "reads per fetch", 64'(reads - r0), 64'd2);

    // R3: out-of-range segment, no reads
    r0 = reads;
    send(6, 0, 0, "R3");
    send(16'hFFFF, 0, 0, "R3");
    drain();
    note(reads == r0, "R3", "no read on length fault", 64'(reads), 64'(r0));

    send(1, 0, 0, "R5");          // absent (also limit 0) -> absent first (R8)
    send(0, 16'h100, 0, "R6");    // offset == limit
    send(0, 16'hFF, 1, "R6");     // limit - 1 accepted
    send(3, 0, 0, "R8");          // limit 0 and no perms -> limit first
    send(2, 16'h3F, 0, "R7");     // read allowed
    send(2, 0, 1, "R7");          // write denied
    send(2, 0, 2, "R7");          // exec denied
    send(2, 0, 3, "R7");          // reserved code
    send(5, 4, 2, "R7");          // exec allowed
    send(5, 4, 0, "R7");          // read denied
    send(4, 16'h20, 0, "R9");     // wraps to 0x10
    send(4, 16'h20, 2, "R9");     // fault -> paddr 0
    send(0, 0, 2, "R10");
    send(5, 16'h10, 2, "R10");
    drain();
    repeat (3) @(negedge clk);
    note(sb.size() == 0, "R10", "all responses returned", 64'(sb.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule